// File: doc/BRIEF.md
# Watchdog Timer with Control and Status Register

This block is a watchdog counter steered by one 8-bit control and status register. The register sits in bits 23 down to 16 of a 32-bit word. Software reaches it through a single write strobe with write data and a read-data bus that always shows the register. Software turns the counter on and must then keep writing a restart command before the period runs out. If it fails to do so, the counter expires and raises a sticky timeout flag.

The timeout flag then drives three level outputs, each gated by a control bit. The board-fail output follows the flag when its enable is set. When the reset enable is set, the flag also drives a reset. A select bit chooses between a local-only reset and a system-wide reset, and the system-wide reset always carries the local reset with it. The flag is cleared only through a write-one-to-clear command bit. The timeout period is the parameter `TIMEOUT_CYCLES`.

Top module: `wdt_top`

## Requirements
- R1: After reset, every control bit and the timeout flag are 0, `regRdData` reads 0, and all three outputs are low.
- R2: In the 32-bit word, bit 16 enables the counter, bit 17 enables the reset, bit 18 selects the system reset (1) or the local reset (0), and bit 19 enables board-fail. Bits 16 to 19 read back as written. Bit 20 is the read-only timeout flag. Bit 21 (restart) and bit 22 (clear flag) are command bits that always read 0. All other bits read 0, and writing bit 20 has no effect.
- R3: The counter advances only while the enable bit is 1. While enable is 0 the count is held at zero and no timeout occurs, so after re-enabling a full period is needed.
- R4: Suppose the enable is written, or a restart is written, at clock edge E. If no further restart is written, the timeout flag reads 1 after edge E+`TIMEOUT_CYCLES` and 0 before it.
- R5: A write with bit 21 set zeroes the count at that edge. Restarts spaced closer than the period prevent any timeout. A write with bit 21 clear does not restart the count.
- R6: The counter saturates at the period and does not wrap. After the flag has been cleared, a saturated counter raises no new timeout until it is restarted or disabled.
- R7: The timeout flag stays set until a write with bit 22 set clears it. A write with bit 22 clear leaves it set.
- R8: If a clear-flag write lands on the same edge as an expiry, the expiry wins and the flag is set.
- R9: While the flag and the reset enable are both 1, `localResetOut` is high. If the select bit is also 1, `sysResetOut` is high as well. With the reset enable at 0, neither reset output is asserted.
- R10: `boardFailOut` is high exactly while the flag and the board-fail enable are both 1.
- R11: The reset and board-fail outputs are levels that follow the live control bits: clearing an enable drops the output while the flag stays set, and setting the enable again raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWrData | input | 32 | Write data; the register uses bits 23:16 |
| regRdData | output | 32 | Register read-back; bits 23:16 carry the register |
| sysResetOut | output | 1 | System-wide reset request (level) |
| localResetOut | output | 1 | Local reset request (level) |
| boardFailOut | output | 1 | Board-fail indication (level) |

## Verification
The bench uses a shortened period. It lands a clear-flag write exactly on the expiry edge, and a design that let the clear win would lose the timeout. It checks the flag one edge before and one edge after expiry, which catches a counter that is off by one. It also disables the counter in the middle of a run and re-enables it, so a design that froze the count instead of zeroing it would expire early. After clearing the flag, it leaves a saturated counter running, and a design that wrapped would raise a second timeout. It also writes zero command bits and bit 20, so command bits that were level-sensitive, or a flag that software could write, would show up as wrong read-back or wrong timing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Positions inside the 32-bit register word.
  localparam int BIT_ENABLE  = 16;
  localparam int BIT_RSTEN   = 17;
  localparam int BIT_SYSSEL  = 18;
  localparam int BIT_FAILEN  = 19;
  localparam int BIT_STATUS  = 20;
  localparam int BIT_RESTART = 21;
  localparam int BIT_CLRFLAG = 22;
  localparam int REG_LSB     = 16;
  localparam int REG_MSB     = 23;

  // Strobes from the control side to the counter datapath.
  typedef struct packed {
    logic run;
    logic restart;
  } cntCmd_t;

  // Software-owned control bits.
  typedef struct packed {
    logic failEn;
    logic sysSel;
    logic rstEn;
    logic enable;
  } ctrlBits_t;

endpackage

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCmd_t cmd,
  output logic    expire
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntD;

  // The expiry event fires on the edge that moves the count onto the cap.
  assign expire = cmd.run && !cmd.restart && (cntQ == CNT_LAST);

  always_comb begin
    cntD = cntQ;
    if (!cmd.run) begin
      cntD = '0;
    end else if (cmd.restart) begin
      cntD = '0;
    end else if (cntQ != CNT_CAP) begin
      cntD = cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else begin
      cntQ <= cntD;
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.run |=> (cntQ == '0)); // R3
  AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> (cntQ == '0)); // R5
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && !cmd.restart && cntQ == CNT_CAP) |=> (cntQ == CNT_CAP)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_CAP); // R6
  AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> !expire); // R6

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrByte,
  input  logic        expire,
  output cntCmd_t     cmd,
  output logic [31:0] rdData,
  output logic        sysResetOut,
  output logic        localResetOut,
  output logic        boardFailOut
);

  localparam int OFF_ENABLE  = BIT_ENABLE  - REG_LSB;
  localparam int OFF_RSTEN   = BIT_RSTEN   - REG_LSB;
  localparam int OFF_SYSSEL  = BIT_SYSSEL  - REG_LSB;
  localparam int OFF_FAILEN  = BIT_FAILEN  - REG_LSB;
  localparam int OFF_STATUS  = BIT_STATUS  - REG_LSB;
  localparam int OFF_RESTART = BIT_RESTART - REG_LSB;
  localparam int OFF_CLRFLAG = BIT_CLRFLAG - REG_LSB;

  ctrlBits_t ctrlQ;
  logic      statusQ;
  logic      clearReq;
  logic      statusD;
  logic [7:0] regByte;

  assign clearReq    = wrEn && wrByte[OFF_CLRFLAG];
  assign cmd.run     = ctrlQ.enable;
  assign cmd.restart = wrEn && wrByte[OFF_RESTART];

  // Expiry takes precedence over a clear arriving on the same edge.
  always_comb begin
    statusD = statusQ;
    if (expire) begin
      statusD = 1'b1;
    end else if (clearReq) begin
      statusD = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      statusQ <= 1'b0;
    end else begin
      statusQ <= statusD;
      if (wrEn) begin
        ctrlQ.enable <= wrByte[OFF_ENABLE];
        ctrlQ.rstEn  <= wrByte[OFF_RSTEN];
        ctrlQ.sysSel <= wrByte[OFF_SYSSEL];
        ctrlQ.failEn <= wrByte[OFF_FAILEN];
      end
    end
  end

  always_comb begin
    regByte              = '0;
    regByte[OFF_ENABLE]  = ctrlQ.enable;
    regByte[OFF_RSTEN]   = ctrlQ.rstEn;
    regByte[OFF_SYSSEL]  = ctrlQ.sysSel;
    regByte[OFF_FAILEN]  = ctrlQ.failEn;
    regByte[OFF_STATUS]  = statusQ;
    rdData               = '0;
    rdData[REG_MSB:REG_LSB] = regByte;
  end

  assign localResetOut = statusQ && ctrlQ.rstEn;
  assign sysResetOut   = statusQ && ctrlQ.rstEn && ctrlQ.sysSel;
  assign boardFailOut  = statusQ && ctrlQ.failEn;

  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> statusQ); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && !clearReq) |=> statusQ); // R7
  AST_FLAG_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!statusQ && !expire) |=> !statusQ); // R7
  AST_EXPIRE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (expire && clearReq) |=> statusQ); // R8
  AST_SYS_CARRIES_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    sysResetOut |-> localResetOut); // R9
  AST_QUIET_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !statusQ |-> (!boardFailOut && !localResetOut && !sysResetOut)); // R10
  AST_NO_EXPIRE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.enable |-> !expire); // R3

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        sysResetOut,
  output logic        localResetOut,
  output logic        boardFailOut
);

  cntCmd_t cntCmd;
  logic    cntExpire;
  logic    unusedWrBits;

  assign unusedWrBits = ^{regWrData[31:REG_MSB+1], regWrData[REG_LSB-1:0]};

  wdt_regs u_regs (
    .clk           (clk),
    .rstN          (rstN),
    .wrEn          (regWrEn),
    .wrByte        (regWrData[REG_MSB:REG_LSB]),
    .expire        (cntExpire),
    .cmd           (cntCmd),
    .rdData        (regRdData),
    .sysResetOut   (sysResetOut),
    .localResetOut (localResetOut),
    .boardFailOut  (boardFailOut)
  );

  wdt_count #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_count (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cntCmd),
    .expire (cntExpire)
  );

endmodule

// File: tb/wdt_top_tb_top.sv
`timescale 1ns/1ps
module wdt_top_tb_top;

  localparam int LIM = 20;
  localparam logic [31:0] EN = 32'h0001_0000;
  localparam logic [31:0] RE = 32'h0002_0000;
  localparam logic [31:0] SS = 32'h0004_0000;
  localparam logic [31:0] BF = 32'h0008_0000;
  localparam logic [31:0] ST = 32'h0010_0000;
  localparam logic [31:0] RS = 32'h0020_0000;
  localparam logic [31:0] CL = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sysResetOut, localResetOut, boardFailOut;

  int checkCount = 0;
  int failCount  = 0;
  bit compareOn  = 0;

  // Behavioural reference state.
  int mCnt;
  bit mEn, mRst, mSel, mFail, mStat;

  always #2 clk = ~clk;

  wdt_top #(.TIMEOUT_CYCLES(LIM)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sysResetOut(sysResetOut),
    .localResetOut(localResetOut), .boardFailOut(boardFailOut)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRd();
    logic [31:0] v = '0;
    if (mEn)   v |= EN;
    if (mRst)  v |= RE;
    if (mSel)  v |= SS;
    if (mFail) v |= BF;
    if (mStat) v |= ST;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mEn = 0; mRst = 0; mSel = 0; mFail = 0; mStat = 0;
    end else begin
      bit restart, clear, fire;
      restart = regWrEn && regWrData[21];
      clear   = regWrEn && regWrData[22];
      fire    = mEn && !restart && (mCnt == LIM - 1);
      if (!mEn || restart) mCnt = 0;
      else if (mCnt < LIM) mCnt = mCnt + 1;
      if (fire) mStat = 1;
      else if (clear) mStat = 0;
      if (regWrEn) begin
        mEn = regWrData[16]; mRst = regWrData[17];
        mSel = regWrData[18]; mFail = regWrData[19];
      end
    end
  end

  always @(negedge clk) begin
    if (compareOn) begin
      chk("R2", "readback vs model", regRdData, modelRd());
      chk("R9", "local reset vs model", 32'(localResetOut), 32'(mStat && mRst));
      chk("R9", "system reset vs model", 32'(sysResetOut), 32'(mStat && mRst && mSel));
      chk("R10", "board fail vs model", 32'(boardFailOut), 32'(mStat && mFail));
    end
  end

  task automatic wr(logic [31:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  function automatic logic [31:0] flag();
    return 32'(regRdData[20]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "readback in reset", regRdData, 32'h0);
    chk("R1", "outputs in reset", 32'({sysResetOut, localResetOut, boardFailOut}), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "readback after reset", regRdData, 32'h0);
    compareOn = 1;

    // R3: all routing enabled but counter off.
    wr(RE | SS | BF);
    chk("R2", "control bits read back", regRdData, RE | SS | BF);
    idle(3 * LIM);
    chk("R3", "no timeout while disabled", flag(), 32'h0);

    // R2: writing the flag bit does nothing; command bits read 0.
    wr(EN | RE | BF | ST);
    chk("R2", "flag not writable", regRdData, EN | RE | BF);

    // R5: periodic restart.
    for (int k = 0; k < 6; k++) begin
      idle(LIM - 3);
      wr(EN | RE | BF | RS);
      chk("R2", "restart bit reads 0", regRdData, EN | RE | BF);
    end
    chk("R5", "restarts prevent timeout", flag(), 32'h0);

    // R4: exact expiry edge, local routing.
    idle(LIM - 1);
    chk("R4", "flag one edge before expiry", flag(), 32'h0);
    idle(1);
    chk("R4", "flag at expiry", flag(), 32'h1);
    chk("R9", "local reset asserted", 32'(localResetOut), 32'h1);
    chk("R9", "system reset not selected", 32'(sysResetOut), 32'h0);
    chk("R10", "board fail asserted", 32'(boardFailOut), 32'h1);

    // R6, R7: saturation, stickiness, clear.
    idle(2 * LIM);
    chk("R6", "flag still set after saturation", flag(), 32'h1);
    wr(EN | RE | BF);
    chk("R7", "zero clear bit leaves flag", flag(), 32'h1);
    wr(EN | RE | BF | CL);
    chk("R7", "write-one clears flag", flag(), 32'h0);
    idle(2 * LIM);
    chk("R6", "saturated counter raises no new timeout", flag(), 32'h0);

    // R9: system routing.
    wr(EN | RE | SS | BF | RS);
    idle(LIM);
    chk("R9", "system reset asserted", 32'(sysResetOut), 32'h1);
    chk("R9", "system reset carries local", 32'(localResetOut), 32'h1);

    // R11, R10: live gating.
    wr(EN | SS | BF);
    chk("R11", "reset drops with enable cleared", 32'({sysResetOut, localResetOut}), 32'h0);
    chk("R11", "flag kept while reset gated", flag(), 32'h1);
    wr(EN | RE | SS);
    chk("R10", "board fail gated off", 32'(boardFailOut), 32'h0);
    chk("R11", "reset returns with enable set", 32'({sysResetOut, localResetOut}), 32'h3);

    // R8: clear lands on the expiry edge.
    wr(EN | RE | SS | RS | CL);
    chk("R7", "flag cleared with restart", flag(), 32'h0);
    idle(LIM - 1);
    wr(EN | RE | SS | CL);
    chk("R8", "expiry wins over clear", flag(), 32'h1);

    // R5: zero restart bit is no restart.
    wr(EN | RE | SS | RS | CL);
    idle(LIM - 2);
    wr(EN | RE | SS);
    chk("R5", "no timeout yet", flag(), 32'h0);
    idle(1);
    chk("R5", "zero restart bit did not restart", flag(), 32'h1);

    // R3: disable mid-run zeroes the count.
    wr(CL);
    wr(EN | RS);
    idle(LIM - 3);
    wr(32'h0);
    wr(EN);
    idle(LIM - 1);
    chk("R3", "full period needed after re-enable", flag(), 32'h0);
    idle(1);
    chk("R3", "timeout after full period", flag(), 32'h1);

    compareOn = 0;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule